// File: doc/BRIEF.md
# Cascadable Successive Approximation Register

This block holds the digital side of a successive approximation analog-to-digital converter: the trial sequencing and the result storage. A start request loads a pattern in which the most significant bit is the first trial bit (LOW) and all other bits are HIGH. On every following clock edge, the comparator decision on the serial input is written into the bit under trial, and the next lower bit is pulled LOW to become the new trial. When the least significant bit has received its decision, the conversion-complete flag drops and the register holds until the next start.

The same behaviour makes the block a serial-to-parallel converter or a one-shot ring sequencer. An active-low enable lets several blocks be chained into a longer register. The conversion-complete output of the upper block drives the enable of the lower one, and the serial input, start and clock are shared. An asynchronous active-low reset puts the block into an idle, completed state at power-on, so a continuous loop that feeds start from the complete flag cannot lock up.

Top module: `sar_reg`

## Requirements
- R1: When `start_n` is LOW at a rising edge, the next state has `q[N-1]` = 0, all other `q` bits = 1 and `cc` = 1, provided `en_n` is LOW.
- R2: With `start_n` HIGH, `cc` HIGH and `en_n` LOW, a rising edge writes `d` into the bit under trial and clears the next lower bit, which becomes the new trial bit.
- R3: `cc` goes LOW on the Nth decision edge after the start edge (the ninth edge counted from the start edge when N=8). With an ideal comparator, `q` then equals the target code.
- R4: After completion, while `start_n` stays HIGH, `q` and `cc` hold whatever `d` does.
- R5: While `en_n` is HIGH, `q[N-1]` reads 1, and the stored bits and `cc` do not change except through a start. Trials resume on the first edge after `en_n` falls.
- R6: Two N/2-bit blocks chained through `cc` to `en_n` produce, on every cycle of a conversion, the same `q` and final `cc` as one N-bit block.
- R7: `d_dly` equals `d` as sampled at the previous rising edge.
- R8: `q_msb_n` is always the inverse of the displayed `q[N-1]`.
- R9: While `rst_n` is LOW, `q` is all ones, `cc` is 0 and `d_dly` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| d | input | 1 | Serial comparator decision |
| start_n | input | 1 | Synchronous start, active low |
| en_n | input | 1 | Chain enable, active low |
| q | output | N | Parallel register |
| q_msb_n | output | 1 | Inverse of the displayed MSB |
| cc | output | 1 | HIGH while converting, LOW when complete |
| d_dly | output | 1 | Serial input delayed by one clock |

## Verification
The bench plays an ideal comparator against several targets, including all zeros, all ones and alternating codes. It checks the trial bit on every step, so a design that writes the decision into the wrong bit or forgets to arm the next one fails in the middle of the conversion and not only at the end. A design that drops `cc` one edge early or late breaks the step-by-step `cc` check and also gives a wrong final code. Random `d` after completion catches a register that keeps loading. A held-HIGH enable catches a block that advances, or that leaves its MSB unforced, while its upper neighbour is still working. A chained pair that is off by one edge at the hand-over no longer matches the wide instance at the cycle where the lower block starts.

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d,
  input  logic         start_n,
  input  logic         en_n,
  output logic [N-1:0] q,
  output logic         q_msb_n,
  output logic         cc,
  output logic         d_dly
);
  localparam int PW = (N > 2) ? $clog2(N) : 1;
  localparam logic [N-1:0] MSB_MASK  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] START_PAT = {1'b0, {(N-1){1'b1}}};
  localparam logic [PW-1:0] TOP = PW'(N-1);

  logic [N-1:0]  q_r;
  logic [PW-1:0] ptr;
  logic          busy;
  logic          echo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r  <= '1;
      ptr  <= '0;
      busy <= 1'b0;
      echo <= 1'b0;
    end else begin
      echo <= d;
      if (!start_n) begin
        q_r  <= START_PAT;
        ptr  <= TOP;
        busy <= 1'b1;
      end else if (busy && !en_n) begin
        q_r[ptr] <= d;
        if (ptr != '0) begin
          q_r[ptr - 1'b1] <= 1'b0;
          ptr <= ptr - 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  assign q       = en_n ? (q_r | MSB_MASK) : q_r;
  assign q_msb_n = ~q[N-1];
  assign cc      = busy;
  assign d_dly   = echo;

  AST_START_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> (q_r == START_PAT && busy)); // R1
  AST_TRIAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && busy && !en_n) |=> (q_r[$past(ptr)] == $past(d))); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && !busy) |=> ($stable(q_r) && !busy)); // R4
  AST_EN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && en_n) |=> ($stable(q_r) && $stable(busy))); // R5
  AST_MSB_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (q[N-1] && !q_msb_n)); // R5
  AST_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (d_dly == $past(d))); // R7
endmodule

// File: tb/sar_reg_bench.sv
module sar_reg_bench;
  localparam int N = 8;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d = 1'b0;
  logic start_n = 1'b1;
  logic en_n = 1'b0;
  logic [N-1:0] q;
  logic q_msb_n, cc, d_dly;
  logic [H-1:0] q_hi, q_lo;
  logic hm_n, cc_hi, dd_hi, lm_n, cc_lo, dd_lo;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sar_reg #(.N(N)) u_sar_reg (.clk(clk), .rst_n(rst_n), .d(d), .start_n(start_n),
    .en_n(en_n), .q(q), .q_msb_n(q_msb_n), .cc(cc), .d_dly(d_dly));
  sar_reg #(.N(H)) u_hi (.clk(clk), .rst_n(rst_n), .d(d), .start_n(start_n),
    .en_n(en_n), .q(q_hi), .q_msb_n(hm_n), .cc(cc_hi), .d_dly(dd_hi));
  sar_reg #(.N(H)) u_lo (.clk(clk), .rst_n(rst_n), .d(d), .start_n(start_n),
    .en_n(cc_hi), .q(q_lo), .q_msb_n(lm_n), .cc(cc_lo), .d_dly(dd_lo));

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic decide(input logic [N-1:0] cur, input int i, input logic [N-1:0] tgt);
    logic [N-1:0] code = '0;
    for (int b = N-1; b > i; b--) code[b] = cur[b];
    code[i] = 1'b1;
    return code <= tgt;
  endfunction

  task automatic do_start();
    @(negedge clk) start_n = 1'b0;
    @(negedge clk) start_n = 1'b1;
  endtask

  task automatic decide_all(input logic [N-1:0] tgt);
    for (int i = N-1; i >= 0; i--) begin
      logic dv;
      dv = decide(q, i, tgt);
      d = dv;
      @(negedge clk);
      check(q[i] == dv, "R2 load", q, {N{dv}});
      if (i > 0) check(q[i-1] == 1'b0, "R2 arm", q, '0);
      check(d_dly == dv, "R7 echo", N'(d_dly), N'(dv));
      check(cc == (i > 0), "R3 cc step", N'(cc), N'(i > 0));
      check({q_hi, q_lo} == q, "R6 chain q", {q_hi, q_lo}, q);
      check(q_msb_n == ~q[N-1], "R8 msb_n", N'(q_msb_n), N'(~q[N-1]));
    end
    check(q == tgt, "R3 result", q, tgt);
    check(cc_lo == cc, "R6 chain cc", N'(cc_lo), N'(cc));
  endtask

  task automatic t_power_on();
    #3;
    check(q == '1, "R9 q", q, '1);
    check(cc == 1'b0, "R9 cc", N'(cc), '0);
    check(d_dly == 1'b0, "R9 d_dly", N'(d_dly), '0);
    check(q_msb_n == 1'b0, "R8 msb_n reset", N'(q_msb_n), '0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_convert(input logic [N-1:0] tgt);
    do_start();
    check(q == {1'b0, {(N-1){1'b1}}}, "R1 pattern", q, {1'b0, {(N-1){1'b1}}});
    check(cc == 1'b1, "R1 cc", N'(cc), 1);
    check(q_msb_n == 1'b1, "R8 msb_n start", N'(q_msb_n), 1);
    decide_all(tgt);
  endtask

  task automatic t_hold(input logic [N-1:0] tgt);
    for (int k = 0; k < 6; k++) begin
      d = ~d ^ k[0];
      @(negedge clk);
      check(q == tgt, "R4 hold q", q, tgt);
      check(cc == 1'b0, "R4 hold cc", N'(cc), '0);
    end
  endtask

  task automatic t_enable(input logic [N-1:0] tgt);
    en_n = 1'b1;
    do_start();
    for (int k = 0; k < 5; k++) begin
      d = k[0];
      @(negedge clk);
      check(q == '1, "R5 frozen q", q, '1);
      check(q_msb_n == 1'b0, "R5 msb_n", N'(q_msb_n), '0);
      check(cc == 1'b1, "R5 cc", N'(cc), 1);
    end
    en_n = 1'b0;
    #1;
    check(q[N-1] == 1'b0, "R5 trial shown", q, {1'b0, {(N-1){1'b1}}});
    decide_all(tgt);
  endtask

  initial begin
    t_power_on();
    t_convert(8'hA5);
    t_hold(8'hA5);
    t_convert(8'h00);
    t_convert(8'hFF);
    t_hold(8'hFF);
    t_convert(8'h5A);
    t_convert(8'h81);
    t_enable(8'h3C);
    t_hold(8'h3C);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule